// File: doc/BRIEF.md
# Memory-Mapped Address Decode Fabric

This block sits between a single memory-mapped host and a fixed set of target ports. Each port owns a window given by a base and a mask parameter. When the fabric is idle, it decodes a new read or write request at once and forwards it to the winning port, along with a port-local word index. While the target holds the transfer off, the fabric latches the request and keeps the binding to that port. During that time it returns the target's read data and stall indication to the host, and it releases the binding in the cycle the target reports completion.

Requests that cannot be served never reach a port. These are addresses that are not word aligned, addresses that fall in no window, and requests that ask to read and write at once. Each of these finishes in its own cycle with the stall low and read data zero, and it raises a one-cycle error pulse. A host that changes its request while bound is also reported.

Top module: `mm_decode_fabric`

## Requirements
- R1: Every port window must satisfy base AND mask == base. A window that breaks this stops elaboration.
- R2: A legal request goes only to the lowest-index port whose mask, ANDed with the address, equals that port's base. `p_sel_o` bit i marks port i, and at most one bit is set.
- R3: `p_off_o` equals (address AND NOT mask of the selected port) shifted right by two.
- R4: A request with address bit 1 or bit 0 set selects no port and drives neither `p_rd_o` nor `p_wr_o`. It completes in its cycle with `h_wait_o` low and `h_rdata_o` zero, and `err_unaligned_o` is high for the following cycle.
- R5: An aligned request that matches no window selects no port and completes in its cycle with `h_rdata_o` zero. `err_hole_o` is high for the following cycle.
- R6: Read and write requested together selects no port and completes in its cycle. `err_rdwr_o` is high for the following cycle.
- R7: `h_wait_o` is high while the selected port's done input is low. A target that needs L cycles stalls the host for exactly L cycles. Once bound, the port and the offset stay fixed until done.
- R8: While bound, any change of the host address, read, write, write data or byte enables raises `err_proto_o` in the following cycle.
- R9: On writes `p_wdata_o` and `p_be_o` carry the host values and `p_wr_o` is high. On reads `p_be_o` is zero.
- R10: A completed read returns the selected port's read data on `h_rdata_o`.
- R11: Reset clears the binding and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_addr_i | input | ADDR_W | Host byte address |
| h_rd_i | input | 1 | Host read request |
| h_wr_i | input | 1 | Host write request |
| h_wdata_i | input | DATA_W | Host write data |
| h_be_i | input | DATA_W/8 | Host byte enables |
| h_rdata_o | output | DATA_W | Read data to host |
| h_wait_o | output | 1 | Stall to host |
| err_unaligned_o | output | 1 | Unaligned request pulse |
| err_hole_o | output | 1 | Unmapped request pulse |
| err_rdwr_o | output | 1 | Read-and-write request pulse |
| err_proto_o | output | 1 | Request changed while bound |
| p_sel_o | output | N_PORTS | One-hot port select |
| p_rd_o | output | 1 | Read strobe to ports |
| p_wr_o | output | 1 | Write strobe to ports |
| p_off_o | output | ADDR_W-2 | Port-local word index |
| p_wdata_o | output | DATA_W | Write data to ports |
| p_be_o | output | DATA_W/8 | Byte enables to ports |
| p_rdata_i | input | N_PORTS x DATA_W | Read data per port |
| p_done_i | input | N_PORTS | Completion per port |

## Verification
The bench uses three windows: two 4 KiB windows and one 64 KiB window that overlaps both. Aligned addresses are swept from the low windows through the overlap and into the unmapped space above it. This separates the priority choice from a plain match and the offset arithmetic from the hole detection. Reads and writes alternate in the sweep, with shifting byte-enable patterns, and the targets have zero, one and two cycles of latency, so same-cycle completion is kept apart from held bindings. Separate patterns cover misaligned offsets, read and write requested together, a host that changes its address while stalled, and a reset in the middle of a transfer.

// File: rtl/mm_fabric_pkg.sv
package mm_fabric_pkg;
  typedef struct packed {
    logic unaligned;
    logic hole;
    logic rdwr;
    logic proto;
  } err_t;
endpackage

// File: rtl/mm_port_match.sv
module mm_port_match #(
  parameter int          ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] MASK = '0,
  localparam int         OFF_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [ADDR_W-1:0] local_addr;

  // R1: window must lie inside its mask
  if ((BASE & MASK) != BASE) begin : a_r1_base_in_mask
    $error("port window base has bits outside its mask");
  end

  assign hit_o      = (addr_i & MASK) == BASE;
  assign local_addr = addr_i & ~MASK;
  assign off_o      = local_addr[ADDR_W-1:2];
endmodule

// File: rtl/mm_first_hit.sv
module mm_first_hit #(
  parameter int N_PORTS = 3,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic [N_PORTS-1:0] hit_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  // descending scan: lowest index is written last and wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_decode_fabric.sv
module mm_decode_fabric
  import mm_fabric_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter logic [N_PORTS-1:0][ADDR_W-1:0] PORT_BASE =
    {32'h0000_0000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [N_PORTS-1:0][ADDR_W-1:0] PORT_MASK =
    {32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_F000},
  localparam int BE_W  = DATA_W / 8,
  localparam int OFF_W = ADDR_W - 2,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               h_addr_i,
  input  logic                            h_rd_i,
  input  logic                            h_wr_i,
  input  logic [DATA_W-1:0]               h_wdata_i,
  input  logic [BE_W-1:0]                 h_be_i,
  output logic [DATA_W-1:0]               h_rdata_o,
  output logic                            h_wait_o,
  output logic                            err_unaligned_o,
  output logic                            err_hole_o,
  output logic                            err_rdwr_o,
  output logic                            err_proto_o,
  output logic [N_PORTS-1:0]              p_sel_o,
  output logic                            p_rd_o,
  output logic                            p_wr_o,
  output logic [OFF_W-1:0]                p_off_o,
  output logic [DATA_W-1:0]               p_wdata_o,
  output logic [BE_W-1:0]                 p_be_o,
  input  logic [N_PORTS-1:0][DATA_W-1:0]  p_rdata_i,
  input  logic [N_PORTS-1:0]              p_done_i
);
  logic              bound_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  err_t              err_q, err_d;

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_rd, cur_wr;
  logic [DATA_W-1:0] cur_wdata;
  logic [BE_W-1:0]   cur_be;

  logic [N_PORTS-1:0]            hit;
  logic [N_PORTS-1:0][OFF_W-1:0] off_all;
  logic [IDX_W-1:0]              pick_idx, sel_idx;
  logic                          any_hit;
  logic                          req, unal, rdwr, fwd, done;

  // idle: decode live host inputs; bound: replay the latched request
  assign cur_addr  = bound_q ? addr_q  : h_addr_i;
  assign cur_rd    = bound_q ? rd_q    : h_rd_i;
  assign cur_wr    = bound_q ? wr_q    : h_wr_i;
  assign cur_wdata = bound_q ? wdata_q : h_wdata_i;
  assign cur_be    = bound_q ? be_q    : h_be_i;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    mm_port_match #(
      .ADDR_W (ADDR_W),
      .BASE   (PORT_BASE[g]),
      .MASK   (PORT_MASK[g])
    ) u_match (
      .addr_i (cur_addr),
      .hit_o  (hit[g]),
      .off_o  (off_all[g])
    );
  end

  mm_first_hit #(.N_PORTS(N_PORTS)) u_pick (
    .hit_i (hit),
    .idx_o (pick_idx),
    .any_o (any_hit)
  );

  assign req     = cur_rd | cur_wr;
  assign unal    = |cur_addr[1:0];
  assign rdwr    = cur_rd & cur_wr;
  assign fwd     = req & ~unal & ~rdwr & any_hit;
  assign sel_idx = bound_q ? idx_q : pick_idx;
  assign done    = p_done_i[sel_idx];

  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      p_sel_o[i] = fwd && (sel_idx == IDX_W'(i));
    end
  end

  assign p_rd_o    = fwd & cur_rd;
  assign p_wr_o    = fwd & cur_wr;
  assign p_off_o   = off_all[sel_idx];
  assign p_wdata_o = cur_wdata;
  assign p_be_o    = cur_wr ? cur_be : '0;
  assign h_wait_o  = fwd & ~done;
  assign h_rdata_o = (fwd & cur_rd) ? p_rdata_i[sel_idx] : '0;

  always_comb begin
    err_d.unaligned = ~bound_q & req & unal;
    err_d.hole      = ~bound_q & req & ~any_hit;
    err_d.rdwr      = ~bound_q & rdwr;
    err_d.proto     = bound_q & ((h_addr_i != addr_q) | (h_rd_i != rd_q) |
                                 (h_wr_i != wr_q) | (h_wdata_i != wdata_q) |
                                 (h_be_i != be_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bound_q <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
      err_q   <= '0;
    end else begin
      err_q <= err_d;
      if (!bound_q) begin
        if (fwd && !done) begin
          bound_q <= 1'b1;
          idx_q   <= pick_idx;
          addr_q  <= h_addr_i;
          rd_q    <= h_rd_i;
          wr_q    <= h_wr_i;
          wdata_q <= h_wdata_i;
          be_q    <= h_be_i;
        end
      end else if (done) begin
        bound_q <= 1'b0;
      end
    end
  end

  assign err_unaligned_o = err_q.unaligned;
  assign err_hole_o      = err_q.hole;
  assign err_rdwr_o      = err_q.rdwr;
  assign err_proto_o     = err_q.proto;

  a_r2_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p_sel_o));

  a_r4_unaligned_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bound_q && (h_rd_i || h_wr_i) && (h_addr_i[1:0] != 2'b00))
      |-> (p_sel_o == '0 && !h_wait_o && h_rdata_o == '0) ##1 err_unaligned_o);

  a_r6_rdwr_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bound_q && h_rd_i && h_wr_i) |-> (p_sel_o == '0) ##1 err_rdwr_o);

  a_r7_binding_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wait_o |=> ($stable(p_sel_o) && $stable(p_off_o)));

  a_r8_proto_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(h_wait_o) && !$past(bound_q) && h_addr_i != $past(h_addr_i))
      |=> err_proto_o);
endmodule

// File: tb/mm_decode_fabric_tb.sv
`timescale 1ns/1ps
module mm_decode_fabric_tb;
  localparam int N = 3;
  localparam logic [N-1:0][31:0] BASE = {32'h0000_0000, 32'h0000_1000, 32'h0000_0000};
  localparam logic [N-1:0][31:0] MASK = {32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_F000};
  localparam int LAT [N] = '{0, 2, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] h_addr = '0, h_wdata = '0, h_rdata;
  logic h_rd = 1'b0, h_wr = 1'b0, h_wait;
  logic [3:0] h_be = '0, p_be;
  logic e_unal, e_hole, e_rdwr, e_proto;
  logic [N-1:0] p_sel, p_done;
  logic p_rd, p_wr;
  logic [29:0] p_off;
  logic [31:0] p_wdata;
  logic [N-1:0][31:0] p_rdata;
  int cnt [N];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mm_decode_fabric #(.N_PORTS(N), .ADDR_W(32), .DATA_W(32),
                     .PORT_BASE(BASE), .PORT_MASK(MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_addr_i(h_addr), .h_rd_i(h_rd), .h_wr_i(h_wr), .h_wdata_i(h_wdata), .h_be_i(h_be),
    .h_rdata_o(h_rdata), .h_wait_o(h_wait),
    .err_unaligned_o(e_unal), .err_hole_o(e_hole), .err_rdwr_o(e_rdwr), .err_proto_o(e_proto),
    .p_sel_o(p_sel), .p_rd_o(p_rd), .p_wr_o(p_wr), .p_off_o(p_off),
    .p_wdata_o(p_wdata), .p_be_o(p_be), .p_rdata_i(p_rdata), .p_done_i(p_done)
  );

  function automatic logic [31:0] model_rd(int p, logic [29:0] off);
    return 32'hA000_0000 + (32'(p) << 24) + {2'b00, off};
  endfunction

  function automatic int exp_port(logic [31:0] a);
    for (int p = 0; p < N; p++) if ((a & MASK[p]) == BASE[p]) return p;
    return -1;
  endfunction

  // target models: port p completes LAT[p] cycles after first selection
  always_comb begin
    for (int p = 0; p < N; p++) begin
      p_done[p]  = p_sel[p] && (cnt[p] >= LAT[p]);
      p_rdata[p] = model_rd(p, p_off);
    end
  end

  always @(posedge clk or negedge rst_n) begin
    for (int p = 0; p < N; p++) begin
      if (!rst_n) cnt[p] <= 0;
      else if (p_sel[p] && !p_done[p]) cnt[p] <= cnt[p] + 1;
      else cnt[p] <= 0;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  logic [N-1:0] ob_sel;
  logic [29:0]  ob_off;
  logic [3:0]   ob_be;
  logic [31:0]  ob_wd, ob_rdata;
  logic         ob_pwr, ob_prd;
  logic [3:0]   ob_err;
  int           ob_cyc;

  task automatic xfer(logic [31:0] a, logic r, logic w, logic [31:0] wd, logic [3:0] be);
    @(negedge clk);
    h_addr = a; h_rd = r; h_wr = w; h_wdata = wd; h_be = be;
    #1;
    ob_sel = p_sel; ob_off = p_off; ob_be = p_be; ob_wd = p_wdata;
    ob_pwr = p_wr; ob_prd = p_rd; ob_cyc = 0;
    while (h_wait && ob_cyc < 50) begin
      @(negedge clk); #1; ob_cyc++;
    end
    ob_rdata = h_rdata;
    @(negedge clk);
    h_rd = 1'b0; h_wr = 1'b0;
    #1;
    ob_err = {e_unal, e_hole, e_rdwr, e_proto};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk(h_wait == 1'b0 && p_sel == '0, "R11 reset outputs", {31'd0, h_wait}, 32'd0);
    chk({e_unal, e_hole, e_rdwr, e_proto} == 4'b0, "R11 reset flags",
        {28'd0, e_unal, e_hole, e_rdwr, e_proto}, 32'd0);
    rst_n = 1'b1;

    // R1: configured windows respect their masks
    for (int p = 0; p < N; p++)
      chk((BASE[p] & MASK[p]) == BASE[p], "R1 window", BASE[p] & MASK[p], BASE[p]);

    // R2 R3 R5 R7 R9 R10: sweep across windows, overlap and holes
    for (int i = 0; i < 160; i++) begin
      logic [31:0] a, wd;
      logic [3:0] be;
      bit w;
      int p;
      a  = i * 32'h1A4;
      w  = i[0];
      wd = a ^ 32'h5A5A_0000;
      be = 4'(i * 7);
      p  = exp_port(a);
      xfer(a, !w, w, wd, be);
      chk(ob_sel == ((p < 0) ? 3'b000 : 3'(1 << p)), "R2 select", {29'd0, ob_sel},
          (p < 0) ? 32'd0 : (32'd1 << p));
      if (p >= 0) begin
        chk(ob_off == 30'((a & ~MASK[p]) >> 2), "R3 offset", {2'b0, ob_off},
            (a & ~MASK[p]) >> 2);
        chk(ob_cyc == LAT[p], "R7 stall cycles", 32'(ob_cyc), 32'(LAT[p]));
        chk(ob_err[2] == 1'b0, "R5 no hole flag", {31'd0, ob_err[2]}, 32'd0);
        if (w) begin
          chk(ob_pwr && !ob_prd && ob_wd == wd, "R9 write data", ob_wd, wd);
          chk(ob_be == be, "R9 write byte enables", {28'd0, ob_be}, {28'd0, be});
        end else begin
          chk(ob_be == 4'd0, "R9 read byte enables", {28'd0, ob_be}, 32'd0);
          chk(ob_rdata == model_rd(p, ob_off), "R10 read data", ob_rdata,
              model_rd(p, 30'((a & ~MASK[p]) >> 2)));
        end
      end else begin
        chk(ob_err[2] == 1'b1, "R5 hole flag", {31'd0, ob_err[2]}, 32'd1);
        chk(ob_cyc == 0 && ob_rdata == 0, "R5 hole response", ob_rdata, 32'd0);
      end
    end

    // R4: misaligned requests
    for (int k = 1; k < 4; k++) begin
      logic [31:0] a;
      a = 32'h0000_1100 + 32'(k);
      xfer(a, k != 2, k == 2, 32'hDEAD_BEEF, 4'hF);
      chk(ob_sel == '0 && !ob_pwr && !ob_prd, "R4 not forwarded", {29'd0, ob_sel}, 32'd0);
      chk(ob_cyc == 0 && ob_rdata == 0, "R4 response", ob_rdata, 32'd0);
      chk(ob_err == 4'b1000, "R4 unaligned flag", {28'd0, ob_err}, 32'h8);
    end

    // R6: read and write together
    xfer(32'h0000_1000, 1'b1, 1'b1, 32'h1, 4'hF);
    chk(ob_sel == '0 && ob_cyc == 0, "R6 not forwarded", {29'd0, ob_sel}, 32'd0);
    chk(ob_err == 4'b0010, "R6 rdwr flag", {28'd0, ob_err}, 32'h2);

    // R8 R7: host changes address while bound to port 1 (two-cycle target)
    @(negedge clk);
    h_addr = 32'h0000_1010; h_rd = 1'b1;
    #1;
    chk(h_wait == 1'b1, "R7 stall on slow target", {31'd0, h_wait}, 32'd1);
    @(negedge clk);
    h_addr = 32'h0000_1020;
    #1;
    chk(p_off == 30'h4 && p_sel == 3'b010, "R7 binding kept", {2'b0, p_off}, 32'h4);
    @(negedge clk); #1;
    chk(e_proto == 1'b1, "R8 proto flag", {31'd0, e_proto}, 32'd1);
    chk(h_wait == 1'b0, "R7 completes", {31'd0, h_wait}, 32'd0);
    @(negedge clk);
    h_rd = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(e_proto == 1'b0, "R8 flag clears when idle", {31'd0, e_proto}, 32'd0);

    // R11: reset in the middle of a stalled transfer
    @(negedge clk);
    h_addr = 32'h0000_1000; h_rd = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; h_rd = 1'b0;
    #1;
    chk(h_wait == 1'b0 && p_sel == '0, "R11 reset drops binding", {29'd0, p_sel}, 32'd0);
    chk({e_unal, e_hole, e_rdwr, e_proto} == 4'b0, "R11 reset clears flags",
        {28'd0, e_unal, e_hole, e_rdwr, e_proto}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    xfer(32'h0000_1008, 1'b1, 1'b0, '0, '0);
    chk(ob_cyc == 2 && ob_rdata == model_rd(1, 30'h2), "R11 clean after reset", ob_rdata,
        model_rd(1, 30'h2));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule